// File: doc/BRIEF.md
# Unary-Digit Decimal Fixed-Point Adder

This block adds two unsigned decimal fixed-point numbers. Each decimal digit of each operand comes in as a group of nine lines. The digit's value is the number of lines that are active. All digit positions add their two counts and the carry from the position below within one cycle. A position whose total reaches ten passes a carry upward and keeps the remainder as its BCD result digit. The sum, an overflow flag, an input-format error flag and a one-hot marker of the decimal point are registered together. They appear one clock after the request.

The split between integer and fractional digits is set at run time by a configuration load. It gives the integer digit count (1 to `INT_MAX`) and the fractional digit count (0 to `FRAC_MAX`). Digit position 0 is always the least significant fractional digit, or the units digit when there are no fractional digits. Positions at and above the configured total are unused. A small controller sequences the block through three states:
- `ST_UNCFG`: after reset, no configuration has been accepted yet.
- `ST_READY`: a configuration is held and no result is being presented.
- `ST_DONE`: a result is presented for one cycle.

The transitions are:
- `cfg_accept`: `ST_UNCFG` to `ST_READY`.
- `add_go`: `ST_READY` or `ST_DONE` to `ST_DONE`.
- `result_retire`: `ST_DONE` to `ST_READY`.
- `reconfig`: a valid load while in `ST_READY` or `ST_DONE` leads to `ST_READY`.

When `add_go` and `reconfig` occur in the same cycle, `add_go` wins. The addition then uses the configuration held before the load.

Top module: `uda_adder`

## Requirements
- R1: Operand digit at position i occupies lines [i*9 +: 9] of `opa_lines` and `opb_lines`. A digit d (0 to 9) is encoded as lines 0 to d-1 active and all others inactive.
- R2: With I integer and F fractional digits configured, let A and B be the operand values scaled by 10^F. Nibble i of `res_bcd` (bits [i*4 +: 4]) is then decimal digit i of (A+B) mod 10^(I+F), for i < I+F. A position whose total reaches ten passes one carry to position i+1.
- R3: `res_ovf` is 1 exactly when A+B is at least 10^(I+F), meaning a carry left the most significant integer digit. That carry appears nowhere else.
- R4: `res_point` is one-hot with bit F set. It is registered with each result.
- R5: A `start` sampled on a clock edge, after a configuration has been accepted, sets `res_valid` for the following cycle only, unless `start` is sampled again.
- R6: A configuration load is accepted only if 1 <= I <= `INT_MAX` and 0 <= F <= `FRAC_MAX`. Otherwise it is ignored and the previous configuration stays in force.
- R7: `start` is ignored until a configuration has been accepted: `res_valid` stays 0.
- R8: Lines of positions at or above I+F have no effect. The result nibbles of those positions are 0.
- R9: A used digit whose lines are not contiguous from line 0 sets `res_therm_err` for that result. The digit still counts as its number of active lines.
- R10: During and right after reset, `res_valid`, `res_bcd`, `res_point`, `res_ovf` and `res_therm_err` are 0.
- R11: Result outputs hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load request for the digit split |
| cfg_int_digits | input | IW = clog2(INT_MAX+1) | Integer digit count I |
| cfg_frac_digits | input | FW = clog2(FRAC_MAX+1) | Fractional digit count F |
| start | input | 1 | Add request |
| opa_lines | input | N*9 (N = INT_MAX+FRAC_MAX) | Operand A, nine unary lines per digit |
| opb_lines | input | N*9 | Operand B, nine unary lines per digit |
| res_valid | output | 1 | Result presented this cycle |
| res_bcd | output | N*4 | Sum digits, BCD, nibble i = position i |
| res_point | output | N | One-hot point marker, bit F |
| res_ovf | output | 1 | Carry out of the top integer digit |
| res_therm_err | output | 1 | A used digit was not a contiguous thermometer |

## Verification
The bench sweeps every legal configuration. In each one it adds random digits, all nines plus all nines, all nines plus one unit, and all zeros. The all-nines-plus-one case carries through every used position. A design that stopped the carry one position early, or took it from the wrong position, would show a stray digit or miss the overflow flag. The bench fills unused positions with random lines, so a design that let them through, or that let a carry climb past the top digit, would show nonzero upper nibbles. It also feeds scattered line patterns, which a design that decoded by highest active line rather than by count would turn into wrong digits, and which must raise the error flag. Rejected configurations and a start before any configuration are also applied. A design that accepted either would move the point marker or produce a result.

// File: rtl/uda_pkg.sv
package uda_pkg;

    localparam int LINES = 9;
    localparam int BCD_W = 4;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_READY = 2'd1,
        ST_DONE  = 2'd2
    } uda_state_e;

    // number of active lines in one digit group
    function automatic logic [3:0] line_count(input logic [LINES-1:0] v);
        logic [3:0] c;
        c = '0;
        for (int k = 0; k < LINES; k++) begin
            c = c + 4'(v[k]);
        end
        return c;
    endfunction

    // true when active lines form a run starting at line 0
    function automatic logic is_thermo(input logic [LINES-1:0] v);
        logic [LINES-1:0] nxt;
        nxt = v + LINES'(1);
        return (v & nxt) == '0;
    endfunction

endpackage

// File: rtl/uda_digit_cell.sv
module uda_digit_cell
    import uda_pkg::*;
(
    input  logic             en,
    input  logic [LINES-1:0] a_lines,
    input  logic [LINES-1:0] b_lines,
    input  logic             carry_in,
    output logic [BCD_W-1:0] digit,
    output logic             carry_out,
    output logic             bad
);

    logic [3:0] cnt_a;
    logic [3:0] cnt_b;
    logic [4:0] acc;

    always_comb begin
        cnt_a     = en ? line_count(a_lines) : 4'd0;
        cnt_b     = en ? line_count(b_lines) : 4'd0;
        acc       = 5'(cnt_a) + 5'(cnt_b) + 5'(en & carry_in);
        carry_out = (acc >= 5'd10);
        digit     = carry_out ? 4'(acc - 5'd10) : acc[3:0];
        bad       = en & (~is_thermo(a_lines) | ~is_thermo(b_lines));
    end

endmodule

// File: rtl/uda_digit_chain.sv
module uda_digit_chain
    import uda_pkg::*;
#(
    parameter int NDIG = 5
) (
    input  logic [NDIG*LINES-1:0] a_vec,
    input  logic [NDIG*LINES-1:0] b_vec,
    input  logic [NDIG-1:0]       used,
    output logic [NDIG*BCD_W-1:0] digits,
    output logic [NDIG:0]         carries,
    output logic [NDIG-1:0]       bad
);

    assign carries[0] = 1'b0;

    for (genvar i = 0; i < NDIG; i++) begin : g_pos
        uda_digit_cell u_cell (
            .en        (used[i]),
            .a_lines   (a_vec[i*LINES +: LINES]),
            .b_lines   (b_vec[i*LINES +: LINES]),
            .carry_in  (carries[i]),
            .digit     (digits[i*BCD_W +: BCD_W]),
            .carry_out (carries[i+1]),
            .bad       (bad[i])
        );
    end

endmodule

// File: rtl/uda_seq.sv
module uda_seq
    import uda_pkg::*;
#(
    parameter int INT_MAX  = 3,
    parameter int FRAC_MAX = 2,
    parameter int IW       = 2,
    parameter int FW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [IW-1:0] cfg_int,
    input  logic [FW-1:0] cfg_frac,
    input  logic          start,
    output logic [IW-1:0] int_q,
    output logic [FW-1:0] frac_q,
    output logic          capture,
    output logic          valid
);

    uda_state_e state_q;
    uda_state_e state_d;
    logic       cfg_in_range;
    logic       cfg_take;

    assign cfg_in_range = (cfg_int != '0) && (cfg_int <= IW'(INT_MAX))
                          && (cfg_frac <= FW'(FRAC_MAX));
    assign cfg_take = cfg_load & cfg_in_range;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNCFG;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG: if (cfg_take) state_d = ST_READY;                    // cfg_accept
            ST_READY: if (start) state_d = ST_DONE;                        // add_go
                      else if (cfg_take) state_d = ST_READY;               // reconfig
            ST_DONE:  if (start) state_d = ST_DONE;                        // add_go
                      else state_d = ST_READY;                             // result_retire / reconfig
            default:  state_d = ST_UNCFG;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_UNCFG: begin capture = 1'b0;  valid = 1'b0; end
            ST_READY: begin capture = start; valid = 1'b0; end
            ST_DONE:  begin capture = start; valid = 1'b1; end
            default:  begin capture = 1'b0;  valid = 1'b0; end
        endcase
    end

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (cfg_take) begin
            int_q  <= cfg_int;
            frac_q <= cfg_frac;
        end
    end

    // R6
    bad_cfg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !cfg_in_range) |=> ($stable(int_q) && $stable(frac_q)));

    // R7
    no_start_unconfigured_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNCFG) |=> (state_q != ST_DONE));

endmodule

// File: rtl/uda_adder.sv
module uda_adder
    import uda_pkg::*;
#(
    parameter int INT_MAX  = 3,
    parameter int FRAC_MAX = 2,
    localparam int NDIG    = INT_MAX + FRAC_MAX,
    localparam int IW      = $clog2(INT_MAX + 1),
    localparam int FW      = $clog2(FRAC_MAX + 1),
    localparam int TW      = $clog2(NDIG + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic [IW-1:0]          cfg_int_digits,
    input  logic [FW-1:0]          cfg_frac_digits,
    input  logic                   start,
    input  logic [NDIG*LINES-1:0]  opa_lines,
    input  logic [NDIG*LINES-1:0]  opb_lines,
    output logic                   res_valid,
    output logic [NDIG*BCD_W-1:0]  res_bcd,
    output logic [NDIG-1:0]        res_point,
    output logic                   res_ovf,
    output logic                   res_therm_err
);

    logic [IW-1:0]         int_q;
    logic [FW-1:0]         frac_q;
    logic                  capture;
    logic [TW-1:0]         top;
    logic [NDIG-1:0]       used;
    logic [NDIG*BCD_W-1:0] digits;
    logic [NDIG:0]         carries;
    logic [NDIG-1:0]       bad;

    uda_seq #(
        .INT_MAX  (INT_MAX),
        .FRAC_MAX (FRAC_MAX),
        .IW       (IW),
        .FW       (FW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_int  (cfg_int_digits),
        .cfg_frac (cfg_frac_digits),
        .start    (start),
        .int_q    (int_q),
        .frac_q   (frac_q),
        .capture  (capture),
        .valid    (res_valid)
    );

    assign top = TW'(int_q) + TW'(frac_q);

    for (genvar i = 0; i < NDIG; i++) begin : g_mask
        assign used[i] = (TW'(i) < top);
    end

    uda_digit_chain #(
        .NDIG (NDIG)
    ) u_chain (
        .a_vec   (opa_lines),
        .b_vec   (opb_lines),
        .used    (used),
        .digits  (digits),
        .carries (carries),
        .bad     (bad)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_bcd       <= '0;
            res_point     <= '0;
            res_ovf       <= 1'b0;
            res_therm_err <= 1'b0;
        end else if (capture) begin
            res_bcd       <= digits;
            res_point     <= NDIG'(1) << frac_q;
            res_ovf       <= carries[top];
            res_therm_err <= |bad;
        end
    end

    // R5
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(start));

    // R4
    point_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_point) == 1));

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(res_bcd) && $stable(res_ovf) && $stable(res_point)));

    for (genvar i = 0; i < NDIG; i++) begin : g_chk
        // R2
        bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> (res_bcd[i*BCD_W +: BCD_W] <= 4'd9));
        // R8
        unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && !$past(used[i])) |-> (res_bcd[i*BCD_W +: BCD_W] == 4'd0));
    end

endmodule

// File: tb/tb_uda_adder.sv
module tb_uda_adder;

    localparam int IM = 3;
    localparam int FM = 2;
    localparam int N  = IM + FM;
    localparam int L  = 9;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_load;
    logic [1:0]     cfg_i;
    logic [1:0]     cfg_f;
    logic           start;
    logic [N*L-1:0] pa;
    logic [N*L-1:0] pb;
    logic           res_valid;
    logic [N*4-1:0] res_bcd;
    logic [N-1:0]   res_point;
    logic           res_ovf;
    logic           res_therm_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uda_adder #(.INT_MAX(IM), .FRAC_MAX(FM)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_load        (cfg_load),
        .cfg_int_digits  (cfg_i),
        .cfg_frac_digits (cfg_f),
        .start           (start),
        .opa_lines       (pa),
        .opb_lines       (pb),
        .res_valid       (res_valid),
        .res_bcd         (res_bcd),
        .res_point       (res_point),
        .res_ovf         (res_ovf),
        .res_therm_err   (res_therm_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint p10(input int e);
        longint r = 1;
        for (int k = 0; k < e; k++) r = r * 10;
        return r;
    endfunction

    function automatic logic [L-1:0] th(input int d);
        return L'((1 << d) - 1);
    endfunction

    task automatic load_cfg(input int i, input int f);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_i = 2'(i);
        cfg_f = 2'(f);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // ci/cf: configuration expected to be in force
    task automatic run_add(input int ci, input int cf, input logic [N*L-1:0] a, input logic [N*L-1:0] b);
        int       used;
        longint   va, vb, s, m;
        bit       err;
        logic [N*4-1:0] eb;
        logic [L-1:0] ga, gb;
        used = ci + cf;
        va = 0; vb = 0; err = 0;
        for (int i = 0; i < used; i++) begin
            ga = a[i*L +: L];
            gb = b[i*L +: L];
            va = va + $countones(ga) * p10(i);
            vb = vb + $countones(gb) * p10(i);
            if ((ga & (ga + L'(1))) != '0) err = 1;
            if ((gb & (gb + L'(1))) != '0) err = 1;
        end
        s = va + vb;
        m = s % p10(used);
        eb = '0;
        for (int i = 0; i < used; i++) eb[i*4 +: 4] = 4'((m / p10(i)) % 10);
        @(negedge clk);
        pa = a; pb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(res_valid == 1'b1, "R5 valid", longint'(res_valid), 1);
        chk(res_bcd == eb, "R2 R8 R1 sum", longint'(res_bcd), longint'(eb));
        chk(res_ovf == (s >= p10(used)), "R3 ovf", longint'(res_ovf), longint'(s >= p10(used)));
        chk(res_point == N'(1 << cf), "R4 point", longint'(res_point), longint'(1 << cf));
        chk(res_therm_err == err, "R9 err", longint'(res_therm_err), longint'(err));
        @(negedge clk);
        chk(res_valid == 1'b0, "R5 drop", longint'(res_valid), 0);
    endtask

    function automatic logic [N*L-1:0] make_op(input int k, input int used);
        logic [N*L-1:0] v;
        int pos;
        for (int i = 0; i < N; i++) begin
            if (i < used) v[i*L +: L] = th($urandom_range(9, 0));
            else          v[i*L +: L] = L'($urandom);
        end
        if (k % 7 == 5) begin
            pos = $urandom_range(used - 1, 0);
            v[pos*L +: L] = L'($urandom) | 9'b100000001;
        end
        return v;
    endfunction

    function automatic logic [N*L-1:0] fill(input int d, input int used);
        logic [N*L-1:0] v;
        for (int i = 0; i < N; i++) v[i*L +: L] = (i < used) ? th(d) : L'($urandom);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*L-1:0] a, b, one;
        logic [N*4-1:0] keep;
        rst_n = 1'b0; cfg_load = 1'b0; cfg_i = '0; cfg_f = '0; start = 1'b0; pa = '0; pb = '0;
        repeat (3) @(negedge clk);
        // R10 during reset
        chk(res_valid == 0 && res_bcd == 0 && res_point == 0 && res_ovf == 0 && res_therm_err == 0,
            "R10 in reset", longint'(res_bcd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 0 && res_bcd == 0 && res_point == 0 && res_ovf == 0 && res_therm_err == 0,
            "R10 after reset", longint'(res_point), 0);

        // R7: start before any configuration
        pa = fill(5, N); pb = fill(5, N); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(res_valid == 0, "R7 unconfigured start", longint'(res_valid), 0);
        @(negedge clk);
        chk(res_valid == 0 && res_bcd == 0, "R7 no result", longint'(res_bcd), 0);

        for (int ci = 1; ci <= IM; ci++) begin
            for (int cf = 0; cf <= FM; cf++) begin
                load_cfg(ci, cf);
                for (int k = 0; k < 100; k++) begin
                    if (k == 0) begin a = fill(9, ci + cf); b = fill(9, ci + cf); end
                    else if (k == 1) begin a = fill(0, ci + cf); b = fill(0, ci + cf); end
                    else if (k == 2) begin
                        a = fill(9, ci + cf);
                        b = fill(0, ci + cf);
                        b[L-1:0] = th(1);
                    end
                    else if (k == 3) begin a = fill(9, ci + cf); b = fill(0, ci + cf); end
                    else begin a = make_op(k, ci + cf); b = make_op(k + 3, ci + cf); end
                    run_add(ci, cf, a, b);
                end
            end
        end

        // R11: outputs hold while idle
        keep = res_bcd;
        pa = fill(7, N); pb = fill(8, N);
        repeat (3) @(negedge clk);
        chk(res_bcd == keep && res_valid == 0, "R11 hold", longint'(res_bcd), longint'(keep));

        // R6: rejected loads keep I=2,F=1
        load_cfg(2, 1);
        load_cfg(0, 1);
        load_cfg(2, 3);
        one = '0;
        one[L-1:0] = th(1);
        a = fill(9, 3);
        run_add(2, 1, a, one);
        chk(res_point == 5'b00010, "R6 point kept", longint'(res_point), 2);
        load_cfg(3, 0);
        run_add(3, 0, fill(4, 3), fill(5, 3));
        chk(res_point == 5'b00001, "R6 accepted reload", longint'(res_point), 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule